// File: doc/BRIEF.md
# Paged Buffer Address Generator

This block turns a transfer's buffer description into a stream of byte addresses for a memory mover. The buffer is described by a small array of 32-bit page pointers. Entry 0 points at the first byte, so its low bits carry an offset into a 4 KiB page. Every later entry names the base of a whole 4 KiB page. A transfer starts with a start pulse that latches the pointer array and the total byte count. After that, the mover asks for bursts of bytes. For each accepted burst the block emits one or two segments, each with an address and a length. It never emits a segment that straddles a page boundary.

The block keeps a cursor made of three parts: the current pointer index, the offset within the page, and the bytes that remain. A burst that would run past the end of the current page is cut at the boundary. The rest of that burst is emitted on the following cycle from the top of the next page. The block flags done when the byte count runs out. A start with a length that the pages cannot hold raises an error instead of starting the transfer.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset, `req_ready`, `seg_valid`, `done` and `len_err` are all low, and `seg_addr` and `seg_len` read zero.
- R2: A `start` pulse latches the pointers and the length. Bits [11:0] of entry 0 become the starting in-page offset, so the first segment's address equals entry 0 exactly. For entries 1 to 4, bits [11:0] are ignored and treated as zero.
- R3: A request is accepted on a clock edge where `req_valid`, `req_ready` and a nonzero `req_len` are all present. Its first segment appears with `seg_valid` high in the next cycle. The segment's address is bits [31:12] of the current entry joined to the 12-bit in-page offset.
- R4: A segment that ends exactly at byte 4096 of its page is not split. The next request then starts at offset 0 of the next entry.
- R5: A request that would cross a page boundary is emitted as two segments on consecutive cycles. The first segment ends exactly at the boundary. The second starts at offset 0 of the next entry. `req_ready` is low in the cycle between them.
- R6: A request longer than the remaining byte count is shortened to the remaining count. The remaining count drops by each segment's length.
- R7: `done` rises in the same cycle as the final segment. After that, `req_ready` stays low and requests produce no segments.
- R8: A `start` with a zero total length sets `done` in the next cycle. No segment is emitted, and `req_ready` stays low.
- R9: A `start` with a length greater than 5*4096 minus the entry-0 offset sets `len_err` in the next cycle. `done` and `req_ready` stay low, and no segment is emitted. A length exactly equal to that limit is accepted.
- R10: A request with `req_len` of zero is ignored. It produces no segment and leaves the cursor unchanged.
- R11: A `start` during a transfer takes priority, even while the second half of a split burst is pending. The pending half is discarded and the new transfer begins from its own entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch pointers and length, begin a transfer |
| ptr_list | input | 160 | Five 32-bit page pointers, entry 0 in bits [31:0] |
| total_len | input | 16 | Transfer length in bytes |
| req_valid | input | 1 | Burst request present |
| req_len | input | 12 | Requested burst length in bytes |
| req_ready | output | 1 | A request can be taken this cycle |
| seg_valid | output | 1 | Segment address and length are valid |
| seg_addr | output | 32 | Byte address of the segment's first byte |
| seg_len | output | 12 | Segment length in bytes |
| done | output | 1 | All bytes of the transfer have been issued |
| len_err | output | 1 | Requested length exceeds the pages' reach |

## Verification
Several rules are checked on every cycle:
- every segment fits inside its page and has a nonzero length;
- an accepted request is followed by a segment;
- a zero-length request gives no segment;
- the cycle after a split starts at offset 0;
- done and error each hold `req_ready` low and never rise together.

Other behaviour can only be shown by the directed scenarios, because it needs the pointer values and the running byte count. That covers:
- the exact addresses built from each pointer entry;
- ignoring the low bits of entries 1 to 4;
- clipping to the remaining count;
- the exact capacity limit;
- discarding a pending half on restart.

// File: rtl/pbag_pkg.sv
// Package: shared constants and helpers for the paged address generator.
// Assumes a page is a power of two bytes; the default is 4 KiB.
package pbag_pkg;
    localparam int PAGE_BITS_DEF = 12;
    localparam int NUM_PTRS_DEF  = 5;

    // Bytes that the pointer list can reach, given the entry-0 offset.
    function automatic logic [31:0] reach_bytes(input int num_ptrs, input int page_bits,
                                                 input logic [31:0] first_off);
        return (32'(num_ptrs) << page_bits) - first_off;
    endfunction
endpackage

// File: rtl/pbag_ptr_bank.sv
// Module: pbag_ptr_bank
// Holds the pointer entries latched at transfer start, keeping only the
// page-base bits of each, and returns the base of the selected entry.
// Assumes sel may run one past the last entry after the final page; it
// then returns zero, and the result is unused because the transfer is done.
module pbag_ptr_bank #(
    parameter int NUM_PTRS  = 5,
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 3,
    localparam int BASE_W   = ADDR_W - PAGE_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NUM_PTRS*ADDR_W-1:0] ptr_list,
    input  logic [IDX_W-1:0]           sel,
    output logic [BASE_W-1:0]          page_base
);
    logic [BASE_W-1:0] base_q [NUM_PTRS];

    for (genvar i = 0; i < NUM_PTRS; i++) begin : g_entry
        // Capture the page-base bits of entry i on load; in-page bits are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
            end else if (load) begin
                base_q[i] <= ptr_list[i*ADDR_W+PAGE_BITS +: BASE_W];
            end
        end
    end

    // Select the current entry's base, zero when past the list.
    always_comb begin
        page_base = '0;
        for (int k = 0; k < NUM_PTRS; k++) begin
            if (32'(sel) == 32'(k)) page_base = base_q[k];
        end
    end
endmodule

// File: rtl/pbag_seg_split.sv
// Module: pbag_seg_split
// Works out how much of a burst fits before the page end.
// Step 1 clips the burst to the remaining byte count.
// Step 2 cuts it at the page boundary.
// Assumes BURST_W <= PAGE_BITS, so a burst crosses at most one boundary.
module pbag_seg_split #(
    parameter int LEN_W     = 16,
    parameter int BURST_W   = 12,
    parameter int PAGE_BITS = 12
) (
    input  logic [PAGE_BITS-1:0] offset,
    input  logic [LEN_W-1:0]     remaining,
    input  logic [BURST_W-1:0]   req_len,
    output logic [BURST_W-1:0]   first_len,
    output logic [BURST_W-1:0]   rest_len
);
    localparam logic [LEN_W-1:0] PAGE_SIZE = LEN_W'(1) << PAGE_BITS;

    logic [LEN_W-1:0] room, req_w, clip, first_w, rest_w;

    // Clip to the remaining count, then cut at the page end.
    always_comb begin
        room    = PAGE_SIZE - LEN_W'(offset);
        req_w   = LEN_W'(req_len);
        clip    = (req_w < remaining) ? req_w : remaining;
        first_w = (clip < room) ? clip : room;
        rest_w  = clip - first_w;
    end

    assign first_len = BURST_W'(first_w);
    assign rest_len  = BURST_W'(rest_w);
endmodule

// File: rtl/pbag_cursor.sv
// Module: pbag_cursor
// Tracks the transfer cursor: the page index, the in-page offset, the
// remaining byte count, and a pending second half of a split burst.
// It also registers the segment valid flag and length.
// Assumes first_len and rest_len come from the splitter for the current
// offset and remaining count. start overrides everything else.
module pbag_cursor #(
    parameter int NUM_PTRS  = 5,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16,
    parameter int BURST_W   = 12,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAGE_BITS-1:0] first_off,
    input  logic [LEN_W-1:0]     total_len,
    input  logic                 req_valid,
    input  logic [BURST_W-1:0]   req_len,
    input  logic [BURST_W-1:0]   first_len,
    input  logic [BURST_W-1:0]   rest_len,
    output logic [PAGE_BITS-1:0] offset,
    output logic [LEN_W-1:0]     remaining,
    output logic [IDX_W-1:0]     page_idx,
    output logic                 emit,
    output logic                 req_ready,
    output logic                 seg_valid,
    output logic [BURST_W-1:0]   seg_len,
    output logic                 done,
    output logic                 len_err
);
    import pbag_pkg::*;

    logic                 armed_q, pend_q, done_q, err_q, segv_q;
    logic [BURST_W-1:0]   pend_len_q, seg_len_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [LEN_W-1:0]     rem_q;
    logic [IDX_W-1:0]     page_q;

    logic                 accept, wrap, last, too_long;
    logic [BURST_W-1:0]   take;
    logic [PAGE_BITS:0]   next_sum;
    logic [LEN_W-1:0]     rem_next;

    // Decide whether a segment goes out this cycle, and how the cursor moves.
    always_comb begin
        req_ready = armed_q && !pend_q;
        accept    = req_valid && req_ready && (req_len != '0);
        emit      = !start && (pend_q || accept);
        take      = pend_q ? pend_len_q : first_len;
        next_sum  = {1'b0, off_q} + (PAGE_BITS+1)'(take);
        wrap      = next_sum[PAGE_BITS];
        rem_next  = rem_q - LEN_W'(take);
        last      = (rem_next == '0);
        too_long  = 32'(total_len) > reach_bytes(NUM_PTRS, PAGE_BITS, 32'(first_off));
    end

    // Load on start, otherwise advance the cursor by each emitted segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            pend_q     <= 1'b0;
            pend_len_q <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            segv_q     <= 1'b0;
            seg_len_q  <= '0;
            off_q      <= '0;
            rem_q      <= '0;
            page_q     <= '0;
        end else if (start) begin
            off_q   <= first_off;
            page_q  <= '0;
            rem_q   <= total_len;
            err_q   <= too_long;
            done_q  <= !too_long && (total_len == '0);
            armed_q <= !too_long && (total_len != '0);
            pend_q  <= 1'b0;
            segv_q  <= 1'b0;
        end else begin
            segv_q <= emit;
            if (emit) begin
                seg_len_q <= take;
                off_q     <= wrap ? '0 : next_sum[PAGE_BITS-1:0];
                page_q    <= page_q + IDX_W'(wrap);
                rem_q     <= rem_next;
                pend_q    <= accept && (rest_len != '0);
                if (accept) pend_len_q <= rest_len;
                if (last) begin
                    done_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign offset    = off_q;
    assign remaining = rem_q;
    assign page_idx  = page_q;
    assign seg_valid = segv_q;
    assign seg_len   = seg_len_q;
    assign done      = done_q;
    assign len_err   = err_q;
endmodule

// File: rtl/paged_addr_gen.sv
// Module: paged_addr_gen (top)
// Generates page-bounded segment addresses for one transfer whose buffer
// is a list of page pointers. Entry 0 carries the start offset; the other
// entries are page bases.
// Assumes ptr_list and total_len are valid in the cycle start is high.
module paged_addr_gen #(
    parameter int NUM_PTRS  = 5,
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16,
    parameter int BURST_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_PTRS*ADDR_W-1:0] ptr_list,
    input  logic [LEN_W-1:0]           total_len,
    input  logic                       req_valid,
    input  logic [BURST_W-1:0]         req_len,
    output logic                       req_ready,
    output logic                       seg_valid,
    output logic [ADDR_W-1:0]          seg_addr,
    output logic [BURST_W-1:0]         seg_len,
    output logic                       done,
    output logic                       len_err
);
    localparam int IDX_W  = $clog2(NUM_PTRS + 1);
    localparam int BASE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_BITS-1:0] cur_off;
    logic [LEN_W-1:0]     cur_rem;
    logic [IDX_W-1:0]     cur_page;
    logic [BASE_W-1:0]    cur_base;
    logic [BURST_W-1:0]   first_len, rest_len;
    logic                 emit;
    logic [ADDR_W-1:0]    addr_q;

    pbag_ptr_bank #(
        .NUM_PTRS(NUM_PTRS), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .load(start), .ptr_list(ptr_list),
        .sel(cur_page), .page_base(cur_base)
    );

    pbag_seg_split #(
        .LEN_W(LEN_W), .BURST_W(BURST_W), .PAGE_BITS(PAGE_BITS)
    ) u_split (
        .offset(cur_off), .remaining(cur_rem), .req_len(req_len),
        .first_len(first_len), .rest_len(rest_len)
    );

    pbag_cursor #(
        .NUM_PTRS(NUM_PTRS), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W),
        .BURST_W(BURST_W), .IDX_W(IDX_W)
    ) u_cursor (
        .clk(clk), .rst_n(rst_n), .start(start),
        .first_off(ptr_list[PAGE_BITS-1:0]), .total_len(total_len),
        .req_valid(req_valid), .req_len(req_len),
        .first_len(first_len), .rest_len(rest_len),
        .offset(cur_off), .remaining(cur_rem), .page_idx(cur_page),
        .emit(emit), .req_ready(req_ready), .seg_valid(seg_valid),
        .seg_len(seg_len), .done(done), .len_err(len_err)
    );

    // Register the segment address; the base and offset fields do not overlap, so no adder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (emit) begin
            addr_q <= {cur_base, cur_off};
        end
    end

    assign seg_addr = addr_q;
endmodule

// File: rtl/pbag_checker.sv
// Module: pbag_checker
// Port-level properties of paged_addr_gen, attached with bind.
module pbag_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int BURST_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               req_valid,
    input logic [BURST_W-1:0] req_len,
    input logic               req_ready,
    input logic               seg_valid,
    input logic [ADDR_W-1:0]  seg_addr,
    input logic [BURST_W-1:0] seg_len,
    input logic               done,
    input logic               len_err
);
    localparam logic [PAGE_BITS:0] PAGE_END = (PAGE_BITS+1)'(1) << PAGE_BITS;

    a_r3_seg_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len != '0) && !start) |=> seg_valid);

    a_r5_seg_within_page: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (({1'b0, seg_addr[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(seg_len)) <= PAGE_END));

    a_r5_second_half_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !req_ready && !done && !len_err && !start)
        |=> (seg_valid && (seg_addr[PAGE_BITS-1:0] == '0)));

    a_r6_seg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0));

    a_r7_ready_low_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r7_done_rises_with_seg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (seg_valid || $past(start)));

    a_r9_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!done && !req_ready));

    a_r9_err_only_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> $past(start));

    a_r10_zero_req_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == '0) && !start) |=> !seg_valid);
endmodule

bind paged_addr_gen pbag_checker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .BURST_W(BURST_W)
) u_pbag_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_len(req_len), .req_ready(req_ready), .seg_valid(seg_valid),
    .seg_addr(seg_addr), .seg_len(seg_len), .done(done), .len_err(len_err)
);

// File: tb/paged_addr_gen_bench.sv
// Directed bench for paged_addr_gen. Each scenario task drives its stimulus and checks its own results.
module paged_addr_gen_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [159:0] ptr_list = '0;
    logic [15:0]  total_len = '0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_len = '0;
    logic         req_ready, seg_valid, done, len_err;
    logic [31:0]  seg_addr;
    logic [11:0]  seg_len;

    int checks = 0;
    int errors = 0;

    logic [31:0] bp [5];
    int m_off, m_page, m_rem;

    always #2 clk = ~clk;

    paged_addr_gen u_paged_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_list(ptr_list),
        .total_len(total_len), .req_valid(req_valid), .req_len(req_len),
        .req_ready(req_ready), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .done(done), .len_err(len_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] page_addr(input int page, input int off);
        logic [31:0] b;
        b = (page < 5) ? bp[page] : 32'h0;
        return {b[31:12], 12'(off)};
    endfunction

    task automatic set_ptrs(input logic [31:0] p0, p1, p2, p3, p4);
        bp[0] = p0; bp[1] = p1; bp[2] = p2; bp[3] = p3; bp[4] = p4;
        ptr_list = {p4, p3, p2, p1, p0};
    endtask

    // Pulse start and check the state one cycle later.
    task automatic begin_xfer(input int total, input bit exp_err, input string req);
        start = 1'b1;
        total_len = 16'(total);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        m_off = int'(bp[0][11:0]);
        m_page = 0;
        m_rem = total;
        chk(req, "len_err after start", 32'(len_err), 32'(exp_err));
        chk(req, "done after start", 32'(done), 32'(!exp_err && total == 0));
        chk(req, "ready after start", 32'(req_ready), 32'(!exp_err && total != 0));
        chk(req, "no segment after start", 32'(seg_valid), 32'h0);
    endtask

    // Issue one burst and check every segment against the page model.
    task automatic burst(input int len, input string req);
        int clip, room, first, rest;
        chk(req, "ready before burst", 32'(req_ready), 32'h1);
        clip = (len < m_rem) ? len : m_rem;
        room = 4096 - m_off;
        first = (clip < room) ? clip : room;
        rest = clip - first;
        req_valid = 1'b1;
        req_len = 12'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_len = '0;
        chk(req, "first seg valid", 32'(seg_valid), 32'h1);
        chk(req, "first seg addr", seg_addr, page_addr(m_page, m_off));
        chk(req, "first seg len", 32'(seg_len), 32'(first));
        m_off = m_off + first;
        if (m_off == 4096) begin
            m_off = 0;
            m_page++;
        end
        m_rem = m_rem - first;
        if (rest > 0) begin
            chk("R5", "ready low between halves", 32'(req_ready), 32'h0);
            @(negedge clk);
            chk("R5", "second seg valid", 32'(seg_valid), 32'h1);
            chk("R5", "second seg addr", seg_addr, page_addr(m_page, 0));
            chk("R5", "second seg len", 32'(seg_len), 32'(rest));
            m_off = rest;
            m_rem = m_rem - rest;
        end
        chk("R7", "done tracks remaining", 32'(done), 32'(m_rem == 0));
        chk("R7", "ready tracks remaining", 32'(req_ready), 32'(m_rem != 0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", 32'(req_ready), 32'h0);
        chk("R1", "seg_valid", 32'(seg_valid), 32'h0);
        chk("R1", "done", 32'(done), 32'h0);
        chk("R1", "len_err", 32'(len_err), 32'h0);
        chk("R1", "seg_addr", seg_addr, 32'h0);
        chk("R1", "seg_len", 32'(seg_len), 32'h0);
    endtask

    // R2 R3 R5 R6: offset start, junk low bits in entry 1, split, clipped last burst.
    task automatic t_basic();
        set_ptrs(32'h1000_0100, 32'h2000_0FFF, 32'h3000_0ABC, 32'h4000_0000, 32'h5000_0000);
        begin_xfer(6000, 1'b0, "R2");
        burst(512, "R2");
        burst(1000, "R3");
        burst(2000, "R3");
        burst(3000, "R6");
        chk("R6", "all bytes issued", 32'(m_rem), 32'h0);
    endtask

    // R4 and R7: exact page end, then a request after done is ignored.
    task automatic t_exact_wrap();
        set_ptrs(32'h0A00_0F00, 32'h0B00_0123, 32'h0, 32'h0, 32'h0);
        begin_xfer(1000, 1'b0, "R4");
        burst(256, "R4");
        chk("R4", "next entry at offset 0", 32'(m_off), 32'h0);
        burst(300, "R4");
        burst(500, "R6");
        req_valid = 1'b1;
        req_len = 12'd100;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "no segment after done", 32'(seg_valid), 32'h0);
        chk("R7", "done holds", 32'(done), 32'h1);
    endtask

    task automatic t_zero_len();
        set_ptrs(32'h0C00_0010, 32'h0, 32'h0, 32'h0, 32'h0);
        begin_xfer(0, 1'b0, "R8");
        @(negedge clk);
        chk("R8", "still no segment", 32'(seg_valid), 32'h0);
        chk("R8", "done stays", 32'(done), 32'h1);
    endtask

    // R9: one byte over the limit is refused; the exact limit runs to the last page.
    task automatic t_capacity();
        set_ptrs(32'h1100_0010, 32'h1200_0000, 32'h1300_0000, 32'h1400_0000, 32'h1500_0000);
        begin_xfer(20465, 1'b1, "R9");
        req_valid = 1'b1;
        req_len = 12'd64;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "no segment on error", 32'(seg_valid), 32'h0);
        chk("R9", "error holds", 32'(len_err), 32'h1);
        begin_xfer(20464, 1'b0, "R9");
        for (int i = 0; i < 8 && m_rem > 0; i++) burst(4095, "R9");
        chk("R9", "limit transfer complete", 32'(done), 32'h1);
        chk("R9", "ended on last entry", 32'(m_page), 32'h5);
    endtask

    task automatic t_zero_req();
        set_ptrs(32'h5000_0000, 32'h0, 32'h0, 32'h0, 32'h0);
        begin_xfer(64, 1'b0, "R10");
        req_valid = 1'b1;
        req_len = 12'd0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "no segment for zero request", 32'(seg_valid), 32'h0);
        chk("R10", "still ready", 32'(req_ready), 32'h1);
        burst(64, "R10");
        chk("R10", "cursor unchanged", 32'(done), 32'h1);
    endtask

    // R11: a restart while the second half is pending discards that half.
    task automatic t_restart();
        set_ptrs(32'h3000_0F00, 32'h3100_0000, 32'h0, 32'h0, 32'h0);
        begin_xfer(1000, 1'b0, "R11");
        req_valid = 1'b1;
        req_len = 12'd600;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "first half len", 32'(seg_len), 32'd256);
        set_ptrs(32'h4000_0040, 32'h0, 32'h0, 32'h0, 32'h0);
        begin_xfer(100, 1'b0, "R11");
        burst(100, "R11");
        chk("R11", "new transfer done", 32'(done), 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_exact_wrap();
        t_zero_len();
        t_capacity();
        t_zero_req();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule